// File: doc/BRIEF.md
# Countdown Timer With Packed Control

A programmable down-counter whose whole programming model is one 32-bit word. A single write sets the start count, the run enable and the interrupt enable. The start count is also kept as the reload value. While running, the counter steps down by one on every cycle in which the external tick-enable input is high. The tick that would take the count from one to zero is the zero transition. On that tick the counter loads the reload value again and keeps running.

When interrupts are enabled, the zero transition sets a sticky pending flag. The flag drives the interrupt output and one bit of the shared interrupt status word. Software clears the flag by writing the word with the acknowledge bit set. That bit is a command and is never stored. The block has no tick prescaler and no bus bridge.

Top module: `cdt_timer`

## Requirements
- R1: After reset the count, run enable, interrupt enable and pending flag are all zero, so `rd_data_o`, `irq_o` and `stat_o` read zero.
- R2: A write loads bits 19:0 into both the count and the reload value, bit 24 into the run enable and bit 25 into the interrupt enable. A write takes priority over a tick in the same cycle. `rd_data_o` returns the count in bits 19:0, the run enable in bit 24 and the interrupt enable in bit 25. All other bits read zero.
- R3: While enabled, a tick with a count above one lowers the count by exactly one. A cycle without a tick leaves the count unchanged.
- R4: With the run enable clear, the count holds its value whatever the tick input does.
- R5: A tick while enabled at count one loads the reload value, not zero.
- R6: A zero transition with the interrupt enable set raises `irq_o` on the next cycle. `irq_o` then stays high until it is acknowledged.
- R7: A count of zero stays at zero under ticks and never raises an interrupt.
- R8: A zero transition with the interrupt enable clear leaves `irq_o` low.
- R9: A write with bit 26 set clears the pending flag. Bit 26 always reads back as zero.
- R10: When a zero transition with interrupts enabled and an acknowledge write fall in the same cycle, the flag ends up set.
- R11: `stat_o` carries the pending flag at bit 5 and zero in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word to write |
| rd_data_o | output | 32 | Read-back of count and enables |
| tick_i | input | 1 | Count-step enable |
| irq_o | output | 1 | Sticky timer interrupt |
| stat_o | output | 8 | Contribution to the shared interrupt status word |

## Verification
The zero transition and the acknowledge write can fall in the same clock cycle. The directed case sets the count to one with both enables on. It then drives a tick together with a write that has bit 26 set, while a pending flag is already high. The expected result is that `irq_o` stays high. In the random phase, ticks and acknowledge writes are drawn independently over small counts, so the same collision recurs many times. Each such case is judged against the bench model's rule that the set wins.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned EN_BIT   = 24;
  localparam int unsigned IE_BIT   = 25;
  localparam int unsigned ACK_BIT  = 26;
  localparam int unsigned STAT_POS = 5;

  typedef struct packed {
    logic run;
    logic irq_en;
  } ctrl_t;
endpackage

// File: rtl/cdt_ctrl_reg.sv
module cdt_ctrl_reg #(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  reload_o,
  output cdt_pkg::ctrl_t    ctrl_o,
  output logic              load_o,
  output logic              ack_o
);
  cdt_pkg::ctrl_t   ctrl_q;
  logic [CNT_W-1:0] reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (wr_en_i) begin
      ctrl_q.run    <= wr_data_i[cdt_pkg::EN_BIT];
      ctrl_q.irq_en <= wr_data_i[cdt_pkg::IE_BIT];
      reload_q      <= wr_data_i[CNT_W-1:0];
    end
  end

  assign reload_o = reload_q;
  assign ctrl_o   = ctrl_q;
  assign load_o   = wr_en_i;
  // acknowledge is a command only, never stored
  assign ack_o    = wr_en_i & wr_data_i[cdt_pkg::ACK_BIT];
endmodule

// File: rtl/cdt_down_cnt.sv
module cdt_down_cnt #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_ev_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step, at_one, at_zero;

  assign step    = run_i & tick_i;
  assign at_one  = (cnt_q == CNT_W'(1));
  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                 cnt_d = load_val_i;
    else if (step && at_one)    cnt_d = reload_i;
    else if (step && !at_zero)  cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  // event from pre-write state: a same-cycle write does not hide it
  assign zero_ev_o = step & at_one;
endmodule

// File: rtl/cdt_irq_flag.sv
module cdt_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (set_i)  pend_q <= 1'b1;
    else if (clr_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STAT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              tick_i,
  output logic              irq_o,
  output logic [STAT_W-1:0] stat_o
);
  cdt_pkg::ctrl_t   ctrl;
  logic [CNT_W-1:0] reload, cnt;
  logic             load, ack, zero_ev, pend;

  cdt_ctrl_reg #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .reload_o(reload), .ctrl_o(ctrl), .load_o(load), .ack_o(ack)
  );

  cdt_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .run_i(ctrl.run), .tick_i,
    .load_i(load), .load_val_i(wr_data_i[CNT_W-1:0]), .reload_i(reload),
    .cnt_o(cnt), .zero_ev_o(zero_ev)
  );

  cdt_irq_flag u_irq (
    .clk_i, .rst_ni,
    .set_i(zero_ev & ctrl.irq_en), .clr_i(ack), .pend_o(pend)
  );

  always_comb begin
    rd_data_o                      = '0;
    rd_data_o[CNT_W-1:0]           = cnt;
    rd_data_o[cdt_pkg::EN_BIT]     = ctrl.run;
    rd_data_o[cdt_pkg::IE_BIT]     = ctrl.irq_en;
  end

  assign irq_o = pend;

  for (genvar i = 0; i < STAT_W; i++) begin : g_stat
    if (i == cdt_pkg::STAT_POS) begin : g_hit
      assign stat_o[i] = pend;
    end else begin : g_zero
      assign stat_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STAT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              tick_i,
  input logic              irq_o,
  input logic [STAT_W-1:0] stat_o
);
  logic [CNT_W-1:0] cnt;
  logic             run, ien, zev, ackw;

  assign cnt  = rd_data_o[CNT_W-1:0];
  assign run  = rd_data_o[cdt_pkg::EN_BIT];
  assign ien  = rd_data_o[cdt_pkg::IE_BIT];
  assign zev  = tick_i && run && (cnt == CNT_W'(1));
  assign ackw = wr_en_i && wr_data_i[cdt_pkg::ACK_BIT];

  p_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && tick_i && !wr_en_i && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1)));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_en_i) |=> $stable(cnt));

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ackw) |=> irq_o);

  p_zero_stays_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0 && !wr_en_i) |=> (cnt == '0 && $stable(irq_o)));

  p_ack_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ackw && !(zev && ien)) |=> !irq_o);

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zev && ien) |=> irq_o);

  p_stat_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(stat_o) == int'(irq_o)) && (stat_o[cdt_pkg::STAT_POS] == irq_o));
endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o), .tick_i(tick_i), .irq_o(irq_o), .stat_o(stat_o)
);

// File: tb/sim_cdt_timer.sv
`timescale 1ns/1ps
module sim_cdt_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        tick_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        irq_o;
  logic [7:0]  stat_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model
  logic [19:0] m_cnt, m_rel;
  logic        m_en, m_ie, m_pend;

  always #2 clk_i = ~clk_i;

  cdt_timer u0 (.*);

  function automatic logic [31:0] word(input logic [19:0] c, input bit en, input bit ie, input bit ack);
    logic [31:0] w = '0;
    w[19:0] = c; w[24] = en; w[25] = ie; w[26] = ack;
    return w;
  endfunction

  function automatic logic [31:0] exp_rd();
    return word(m_cnt, m_en, m_ie, 1'b0);
  endfunction

  function automatic void model_step(input bit wr, input logic [31:0] d, input bit tk);
    bit ev = tk && m_en && (m_cnt == 20'd1);
    if (ev && m_ie)        m_pend = 1'b1;
    else if (wr && d[26])  m_pend = 1'b0;
    if (wr) begin
      m_cnt = d[19:0]; m_rel = d[19:0]; m_en = d[24]; m_ie = d[25];
    end else if (ev) m_cnt = m_rel;
    else if (tk && m_en && m_cnt != 20'd0) m_cnt = m_cnt - 20'd1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string req);
    chk(rd_data_o == exp_rd(), req, rd_data_o, exp_rd());
    chk(irq_o == m_pend, req, 32'(irq_o), 32'(m_pend));
    chk(stat_o == (8'(m_pend) << 5), "R11", 32'(stat_o), 32'(8'(m_pend) << 5));
  endtask

  // drive after negedge, model at posedge, check at next negedge
  task automatic cyc(input bit wr, input logic [31:0] d, input bit tk);
    wr_en_i = wr; wr_data_i = d; tick_i = tk;
    @(posedge clk_i);
    model_step(wr, d, tk);
    @(negedge clk_i);
    wr_en_i = 1'b0; tick_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_cnt = '0; m_rel = '0; m_en = 0; m_ie = 0; m_pend = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk_all("R1");
    // R2: load and read-back, ack bit not stored
    cyc(1, word(20'h0ABCD, 0, 1, 1), 0); chk_all("R2");
    // R4: disabled, ticks do nothing
    cyc(0, '0, 1); cyc(0, '0, 1); chk_all("R4");
    // R3 / R5 / R6: run from 3 with irq enabled
    cyc(1, word(20'd3, 1, 1, 0), 0);
    cyc(0, '0, 1); chk_all("R3");
    cyc(0, '0, 0); chk_all("R3");
    cyc(0, '0, 1); chk_all("R3");
    cyc(0, '0, 1); chk_all("R5");
    chk(irq_o == 1'b1, "R6", 32'(irq_o), 32'd1);
    chk(rd_data_o[19:0] == 20'd3, "R5", 32'(rd_data_o[19:0]), 32'd3);
    cyc(0, '0, 1); chk(irq_o == 1'b1, "R6", 32'(irq_o), 32'd1);
    // R9: acknowledge
    cyc(1, word(20'd5, 1, 1, 1), 0); chk_all("R9");
    chk(irq_o == 1'b0, "R9", 32'(irq_o), 32'd0);
    // R10: ack and zero transition together
    cyc(1, word(20'd1, 1, 1, 0), 0);
    cyc(0, '0, 1); chk(irq_o == 1'b1, "R10", 32'(irq_o), 32'd1);
    cyc(1, word(20'd1, 1, 1, 0), 0);
    cyc(1, word(20'd9, 1, 1, 1), 1); chk_all("R10");
    chk(irq_o == 1'b1, "R10", 32'(irq_o), 32'd1);
    // R7: zero stays zero
    cyc(1, word(20'd0, 1, 1, 1), 0);
    repeat (4) cyc(0, '0, 1);
    chk_all("R7");
    chk(irq_o == 1'b0, "R7", 32'(irq_o), 32'd0);
    // R8: irq disabled
    cyc(1, word(20'd1, 1, 0, 0), 0);
    cyc(0, '0, 1); chk_all("R8");
    chk(irq_o == 1'b0, "R8", 32'(irq_o), 32'd0);
    // R4: stop holds value mid-count
    cyc(1, word(20'd6, 1, 1, 0), 0);
    cyc(0, '0, 1);
    cyc(1, word(20'd5, 0, 1, 0), 1);
    repeat (3) cyc(0, '0, 1);
    chk(rd_data_o[19:0] == 20'd5, "R4", 32'(rd_data_o[19:0]), 32'd5);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d = $urandom;
      bit wr = ($urandom_range(0, 15) == 0);
      bit tk = $urandom_range(0, 1) == 1;
      d[19:0] = 20'($urandom_range(0, 6));
      d[24] = ($urandom_range(0, 3) != 0);
      cyc(wr, d, tk);
      chk_all("R2 R3 R5 R6 R9 R10");
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule